// File: doc/BRIEF.md
# Sound Processor Control Slave

This block is the serial control front end of a stereo sound processor. It listens on a two-wire I2C bus at standard-mode rates. It keeps nine 8-bit control registers and presents their decoded fields as static outputs to the analog signal path. These fields cover source selection, mute modes, output phase, drive strength, input gain, volume, loudness, tone and four output attenuators. A host writes a frame made of the chip address with the direction bit set, one register index, and then any number of data bytes. The register index moves forward by one after each data byte.

A frame with the direction bit cleared reads a status byte instead. That byte holds two clipping flags and the zero-crossing mute status, captured live from the analog side at the start of each byte. The block drives the data line only as an active-low pull enable. Both bus lines pass through a two-flop synchroniser running on a fast system clock. Start and stop conditions are found as data-line edges while the clock line is high.

Top module: `snd_i2c_ctl`

## Requirements
- R1: After reset every switch bit is 0 and the tone byte holds 0x01, so treble code is 0 and bass code is 1. All level and attenuator codes are 0.
- R2: The slave answers only the 7-bit address 1000011. It pulls SDA low in the ninth clock of the address byte. On any other address it gives no acknowledge, and it ignores the rest of the frame until the next start condition.
- R3: A direction bit of 1 selects a write. The first byte after the address is the register index. Each later byte is stored at the current index, and the index then rises by one. Every byte is acknowledged.
- R4: A data byte aimed at an index above 0x08 is acknowledged but changes no register.
- R5: The switch byte at index 0x00 decodes bit 7 as zero-cross mute and bit 6 as immediate mute. Bit 5 is raised fan-out and bit 4 is the phase bit, where 0 gives the bridge mode. Bits 3, 2 and 1 are the enables of source 3, source 2 and the floating-ground source, output as src_en[2:0]. Bit 0 is unused.
- R6: Input level (index 0x01) takes the low 4 bits of its byte. Any code above 10 gives 10 on the output, and codes 0 to 10 pass unchanged.
- R7: Volume (index 0x02) takes the low 6 bits. The loudness byte (index 0x03) gives the enable in bit 6 and the level in bits 5:0. Bit 7 of both bytes is ignored.
- R8: The tone byte (index 0x04) gives treble in bits 7:4 and bass in bits 3:0. Indices 0x05, 0x06, 0x07 and 0x08 set the rear-left, front-left, rear-right and front-right attenuators from their low 4 bits.
- R9: A direction bit of 0 selects a read. Each returned byte carries the input clipping flag in bit 7, the tone clipping flag in bit 6 and the zero-cross status in bit 5, with bits 4:0 at 0. The flags are captured when the byte starts, bytes keep coming while the master acknowledges, and a master not-acknowledge ends the transfer with SDA released.
- R10: A stop condition or a start condition releases SDA at once. A stop ends the frame, so no later byte is stored until a new address phase.
- R11: The control outputs change only in the cycle after a data byte of a write frame completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Bus clock line level |
| sda_in | input | 1 | Bus data line level |
| sda_oe | output | 1 | 1 pulls the data line low |
| clip_in_flag | input | 1 | Input stage clipping flag, returned in bit 7 |
| clip_tone_flag | input | 1 | Tone stage clipping flag, returned in bit 6 |
| zc_mute_flag | input | 1 | Zero-cross mute status, returned in bit 5 |
| src_en | output | 3 | Source enables {source 3, source 2, floating-ground source} |
| phase_norm | output | 1 | 0 selects inverted outputs for bridge drive |
| fan_boost | output | 1 | Raised output drive |
| mute_now | output | 1 | Immediate mute request |
| mute_zc | output | 1 | Mute at zero crossing request |
| in_level | output | 4 | Input gain code, saturated to 10 |
| volume | output | 6 | Volume code |
| loud_en | output | 1 | Loudness enable |
| loud_level | output | 6 | Loudness level code |
| treble | output | 4 | Treble code |
| bass | output | 4 | Bass code |
| att_rl | output | 4 | Rear-left attenuator code |
| att_fl | output | 4 | Front-left attenuator code |
| att_rr | output | 4 | Rear-right attenuator code |
| att_fr | output | 4 | Front-right attenuator code |

## Verification
Two functions overlap in a read. The analog flags keep changing while a status byte is being shifted out, and the next byte must load a fresh capture. The bench changes the three flag inputs three bits into the first read byte. It then expects the first byte to show the old flag pattern and the second byte, acknowledged by the master, to show the new pattern. A similar overlap occurs at the end of the map, where a data byte written past index 0x08 gets an acknowledge but no store. That case is judged by the acknowledges the bench sees together with unchanged attenuator outputs.

// File: rtl/snd_i2c_pkg.sv
`timescale 1ns/1ps
package snd_i2c_pkg;
    localparam int BYTE_W    = 8;
    localparam int NUM_REGS  = 9;
    localparam int LVL_W     = 4;
    localparam int VOL_W     = 6;
    localparam int TONE_W    = 4;
    localparam int ATT_W     = 4;
    localparam logic [6:0] DEV_ADDR = 7'b1000011;
    localparam logic [LVL_W-1:0] LVL_MAX = 4'd10;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RX,
        ST_ACK,
        ST_TX,
        ST_MACK
    } eng_state_e;

    typedef enum logic [1:0] {
        PH_ADDR,
        PH_SUB,
        PH_DATA
    } byte_phase_e;

    typedef struct packed {
        logic              zc_mute;
        logic              imm_mute;
        logic              fan;
        logic              phase_n;
        logic [2:0]        src;
        logic [LVL_W-1:0]  level;
        logic [VOL_W-1:0]  vol;
        logic              loud_on;
        logic [VOL_W-1:0]  loud;
        logic [TONE_W-1:0] treb;
        logic [TONE_W-1:0] bass;
        logic [ATT_W-1:0]  att_rl;
        logic [ATT_W-1:0]  att_fl;
        logic [ATT_W-1:0]  att_rr;
        logic [ATT_W-1:0]  att_fr;
    } ctl_fields_t;

    function automatic logic [BYTE_W-1:0] reg_reset_val(input int idx);
        return (idx == 4) ? 8'h01 : 8'h00;
    endfunction
endpackage

// File: rtl/snd_i2c_sync.sv
`timescale 1ns/1ps
module snd_i2c_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det,
    output logic sda_lvl
);
    typedef struct packed {
        logic [SYNC_STAGES-1:0] scl_sh;
        logic [SYNC_STAGES-1:0] sda_sh;
        logic                   scl_old;
        logic                   sda_old;
    } sync_t;

    sync_t sync_d, sync_q;
    logic  scl_s;
    logic  sda_s;

    assign scl_s = sync_q.scl_sh[SYNC_STAGES-1];
    assign sda_s = sync_q.sda_sh[SYNC_STAGES-1];

    always_comb begin
        sync_d         = sync_q;
        sync_d.scl_sh  = {sync_q.scl_sh[SYNC_STAGES-2:0], scl_in};
        sync_d.sda_sh  = {sync_q.sda_sh[SYNC_STAGES-2:0], sda_in};
        sync_d.scl_old = scl_s;
        sync_d.sda_old = sda_s;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '1;
        end else begin
            sync_q <= sync_d;
        end
    end

    assign scl_rise  = scl_s & ~sync_q.scl_old;
    assign scl_fall  = ~scl_s & sync_q.scl_old;
    assign start_det = scl_s & sync_q.scl_old & sync_q.sda_old & ~sda_s;
    assign stop_det  = scl_s & sync_q.scl_old & ~sync_q.sda_old & sda_s;
    assign sda_lvl   = sda_s;
endmodule

// File: rtl/snd_i2c_engine.sv
`timescale 1ns/1ps
module snd_i2c_engine
    import snd_i2c_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_det,
    input  logic              stop_det,
    input  logic              sda_lvl,
    input  logic [BYTE_W-1:0] status_byte,
    output logic              sda_oe,
    output logic              wr_en,
    output logic [BYTE_W-1:0] wr_addr,
    output logic [BYTE_W-1:0] wr_data
);
    localparam int CNT_W = $clog2(BYTE_W + 1);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(BYTE_W);

    typedef struct packed {
        eng_state_e        st;
        byte_phase_e       ph;
        logic              rd;
        logic              mack;
        logic [CNT_W-1:0]  cnt;
        logic [BYTE_W-1:0] sh;
        logic [BYTE_W-1:0] ptr;
        logic              oe;
        logic              we;
        logic [BYTE_W-1:0] wa;
        logic [BYTE_W-1:0] wd;
    } eng_t;

    eng_t eng_d, eng_q;

    always_comb begin
        eng_d    = eng_q;
        eng_d.we = 1'b0;
        if (stop_det) begin
            eng_d.st = ST_IDLE;
            eng_d.oe = 1'b0;
        end else if (start_det) begin
            eng_d.st  = ST_RX;
            eng_d.ph  = PH_ADDR;
            eng_d.cnt = '0;
            eng_d.oe  = 1'b0;
        end else begin
            case (eng_q.st)
                ST_RX: begin
                    if (scl_rise && (eng_q.cnt < CNT_FULL)) begin
                        eng_d.sh  = {eng_q.sh[BYTE_W-2:0], sda_lvl};
                        eng_d.cnt = eng_q.cnt + 1'b1;
                    end else if (scl_fall && (eng_q.cnt == CNT_FULL)) begin
                        eng_d.cnt = '0;
                        case (eng_q.ph)
                            PH_ADDR: begin
                                if (eng_q.sh[BYTE_W-1:1] == DEV_ADDR) begin
                                    eng_d.st = ST_ACK;
                                    eng_d.oe = 1'b1;
                                    eng_d.rd = ~eng_q.sh[0];
                                end else begin
                                    eng_d.st = ST_IDLE;
                                end
                            end
                            PH_SUB: begin
                                eng_d.ptr = eng_q.sh;
                                eng_d.st  = ST_ACK;
                                eng_d.oe  = 1'b1;
                            end
                            default: begin
                                eng_d.we  = 1'b1;
                                eng_d.wa  = eng_q.ptr;
                                eng_d.wd  = eng_q.sh;
                                eng_d.ptr = eng_q.ptr + 1'b1;
                                eng_d.st  = ST_ACK;
                                eng_d.oe  = 1'b1;
                            end
                        endcase
                    end
                end
                ST_ACK: begin
                    if (scl_fall) begin
                        if ((eng_q.ph == PH_ADDR) && eng_q.rd) begin
                            eng_d.st  = ST_TX;
                            eng_d.sh  = status_byte;
                            eng_d.oe  = ~status_byte[BYTE_W-1];
                            eng_d.cnt = CNT_W'(1);
                        end else begin
                            eng_d.st  = ST_RX;
                            eng_d.oe  = 1'b0;
                            eng_d.cnt = '0;
                            eng_d.ph  = (eng_q.ph == PH_ADDR) ? PH_SUB : PH_DATA;
                        end
                    end
                end
                ST_TX: begin
                    if (scl_fall) begin
                        if (eng_q.cnt == CNT_FULL) begin
                            eng_d.oe = 1'b0;
                            eng_d.st = ST_MACK;
                        end else begin
                            eng_d.oe  = ~eng_q.sh[BYTE_W-2];
                            eng_d.sh  = {eng_q.sh[BYTE_W-2:0], 1'b0};
                            eng_d.cnt = eng_q.cnt + 1'b1;
                        end
                    end
                end
                ST_MACK: begin
                    if (scl_rise) begin
                        eng_d.mack = ~sda_lvl;
                    end else if (scl_fall) begin
                        if (eng_q.mack) begin
                            eng_d.st  = ST_TX;
                            eng_d.sh  = status_byte;
                            eng_d.oe  = ~status_byte[BYTE_W-1];
                            eng_d.cnt = CNT_W'(1);
                        end else begin
                            eng_d.st = ST_IDLE;
                        end
                    end
                end
                default: begin
                    eng_d.st = ST_IDLE;
                    eng_d.oe = 1'b0;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            eng_q    <= '0;
            eng_q.st <= ST_IDLE;
            eng_q.ph <= PH_ADDR;
        end else begin
            eng_q <= eng_d;
        end
    end

    assign sda_oe  = eng_q.oe;
    assign wr_en   = eng_q.we;
    assign wr_addr = eng_q.wa;
    assign wr_data = eng_q.wd;
endmodule

// File: rtl/snd_ctl_regfile.sv
`timescale 1ns/1ps
module snd_ctl_regfile
    import snd_i2c_pkg::*;
#(
    parameter int REG_COUNT = NUM_REGS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [BYTE_W-1:0] wr_addr,
    input  logic [BYTE_W-1:0] wr_data,
    output ctl_fields_t       fields
);
    logic [BYTE_W-1:0] bank_d [REG_COUNT];
    logic [BYTE_W-1:0] bank_q [REG_COUNT];

    always_comb begin
        for (int i = 0; i < REG_COUNT; i++) begin
            bank_d[i] = (wr_en && (wr_addr == BYTE_W'(i))) ? wr_data : bank_q[i];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < REG_COUNT; i++) begin
                bank_q[i] <= reg_reset_val(i);
            end
        end else begin
            for (int i = 0; i < REG_COUNT; i++) begin
                bank_q[i] <= bank_d[i];
            end
        end
    end

    always_comb begin
        fields.zc_mute  = bank_q[0][7];
        fields.imm_mute = bank_q[0][6];
        fields.fan      = bank_q[0][5];
        fields.phase_n  = bank_q[0][4];
        fields.src      = bank_q[0][3:1];
        fields.level    = (bank_q[1][LVL_W-1:0] > LVL_MAX) ? LVL_MAX : bank_q[1][LVL_W-1:0];
        fields.vol      = bank_q[2][VOL_W-1:0];
        fields.loud_on  = bank_q[3][6];
        fields.loud     = bank_q[3][VOL_W-1:0];
        fields.treb     = bank_q[4][BYTE_W-1:TONE_W];
        fields.bass     = bank_q[4][TONE_W-1:0];
        fields.att_rl   = bank_q[5][ATT_W-1:0];
        fields.att_fl   = bank_q[6][ATT_W-1:0];
        fields.att_rr   = bank_q[7][ATT_W-1:0];
        fields.att_fr   = bank_q[8][ATT_W-1:0];
    end
endmodule

// File: rtl/snd_i2c_ctl.sv
`timescale 1ns/1ps
module snd_i2c_ctl
    import snd_i2c_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_in,
    input  logic              sda_in,
    output logic              sda_oe,
    input  logic              clip_in_flag,
    input  logic              clip_tone_flag,
    input  logic              zc_mute_flag,
    output logic [2:0]        src_en,
    output logic              phase_norm,
    output logic              fan_boost,
    output logic              mute_now,
    output logic              mute_zc,
    output logic [LVL_W-1:0]  in_level,
    output logic [VOL_W-1:0]  volume,
    output logic              loud_en,
    output logic [VOL_W-1:0]  loud_level,
    output logic [TONE_W-1:0] treble,
    output logic [TONE_W-1:0] bass,
    output logic [ATT_W-1:0]  att_rl,
    output logic [ATT_W-1:0]  att_fl,
    output logic [ATT_W-1:0]  att_rr,
    output logic [ATT_W-1:0]  att_fr
);
    logic              scl_rise;
    logic              scl_fall;
    logic              start_det;
    logic              stop_det;
    logic              sda_lvl;
    logic              wr_en;
    logic [BYTE_W-1:0] wr_addr;
    logic [BYTE_W-1:0] wr_data;
    logic [BYTE_W-1:0] status_byte;
    ctl_fields_t       fields;

    assign status_byte = {clip_in_flag, clip_tone_flag, zc_mute_flag, 5'b00000};

    snd_i2c_sync #(
        .SYNC_STAGES(SYNC_STAGES)
    ) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_in    (scl_in),
        .sda_in    (sda_in),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det),
        .sda_lvl   (sda_lvl)
    );

    snd_i2c_engine u_engine (
        .clk         (clk),
        .rst_n       (rst_n),
        .scl_rise    (scl_rise),
        .scl_fall    (scl_fall),
        .start_det   (start_det),
        .stop_det    (stop_det),
        .sda_lvl     (sda_lvl),
        .status_byte (status_byte),
        .sda_oe      (sda_oe),
        .wr_en       (wr_en),
        .wr_addr     (wr_addr),
        .wr_data     (wr_data)
    );

    snd_ctl_regfile #(
        .REG_COUNT(NUM_REGS)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .fields  (fields)
    );

    assign mute_zc    = fields.zc_mute;
    assign mute_now   = fields.imm_mute;
    assign fan_boost  = fields.fan;
    assign phase_norm = fields.phase_n;
    assign src_en     = fields.src;
    assign in_level   = fields.level;
    assign volume     = fields.vol;
    assign loud_en    = fields.loud_on;
    assign loud_level = fields.loud;
    assign treble     = fields.treb;
    assign bass       = fields.bass;
    assign att_rl     = fields.att_rl;
    assign att_fl     = fields.att_fl;
    assign att_rr     = fields.att_rr;
    assign att_fr     = fields.att_fr;
endmodule

module snd_i2c_ctl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       start_det,
    input logic       stop_det,
    input logic       sda_oe,
    input logic       wr_en,
    input logic [7:0] wr_addr,
    input logic [3:0] in_level,
    input logic [5:0] volume,
    input logic [3:0] treble,
    input logic [3:0] bass,
    input logic [3:0] att_fr
);
    // R10
    stop_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> !sda_oe);

    // R10
    start_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> !sda_oe);

    // R6
    level_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_level <= 4'd10);

    // R11
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> ($stable(volume) && $stable(treble) && $stable(bass) && $stable(att_fr)));

    // R4
    high_index_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (wr_addr > 8'h08)) |=> ($stable(volume) && $stable(in_level) && $stable(att_fr)));
endmodule

bind snd_i2c_ctl snd_i2c_ctl_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_det (start_det),
    .stop_det  (stop_det),
    .sda_oe    (sda_oe),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .in_level  (in_level),
    .volume    (volume),
    .treble    (treble),
    .bass      (bass),
    .att_fr    (att_fr)
);

// File: tb/snd_i2c_ctl_bench.sv
`timescale 1ns/1ps
module snd_i2c_ctl_bench;
    localparam int Q = 25;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic clip_in_flag = 1'b0;
    logic clip_tone_flag = 1'b0;
    logic zc_mute_flag = 1'b0;
    logic sda_oe;
    logic sda_line;
    logic [2:0] src_en;
    logic phase_norm, fan_boost, mute_now, mute_zc, loud_en;
    logic [3:0] in_level, treble, bass, att_rl, att_fl, att_rr, att_fr;
    logic [5:0] volume, loud_level;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;
    logic [7:0] mdl [9];

    typedef struct {
        int    sel;
        int    exp;
        string req;
    } item_t;
    item_t sbq[$];
    event  sb_evt;

    assign sda_line = sda_m & ~sda_oe;

    always #2.5 clk = ~clk;

    snd_i2c_ctl u_snd_i2c_ctl (
        .clk            (clk),
        .rst_n          (rst_n),
        .scl_in         (scl_m),
        .sda_in         (sda_line),
        .sda_oe         (sda_oe),
        .clip_in_flag   (clip_in_flag),
        .clip_tone_flag (clip_tone_flag),
        .zc_mute_flag   (zc_mute_flag),
        .src_en         (src_en),
        .phase_norm     (phase_norm),
        .fan_boost      (fan_boost),
        .mute_now       (mute_now),
        .mute_zc        (mute_zc),
        .in_level       (in_level),
        .volume         (volume),
        .loud_en        (loud_en),
        .loud_level     (loud_level),
        .treble         (treble),
        .bass           (bass),
        .att_rl         (att_rl),
        .att_fl         (att_fl),
        .att_rr         (att_rr),
        .att_fr         (att_fr)
    );

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int exp_of(input int sel);
        case (sel)
            0:  return int'(mdl[0][3:1]);
            1:  return int'(mdl[0][4]);
            2:  return int'(mdl[0][5]);
            3:  return int'(mdl[0][6]);
            4:  return int'(mdl[0][7]);
            5:  return (int'(mdl[1][3:0]) > 10) ? 10 : int'(mdl[1][3:0]);
            6:  return int'(mdl[2][5:0]);
            7:  return int'(mdl[3][6]);
            8:  return int'(mdl[3][5:0]);
            9:  return int'(mdl[4][7:4]);
            10: return int'(mdl[4][3:0]);
            11: return int'(mdl[5][3:0]);
            12: return int'(mdl[6][3:0]);
            13: return int'(mdl[7][3:0]);
            default: return int'(mdl[8][3:0]);
        endcase
    endfunction

    function automatic int obs_of(input int sel);
        case (sel)
            0:  return int'(src_en);
            1:  return int'(phase_norm);
            2:  return int'(fan_boost);
            3:  return int'(mute_now);
            4:  return int'(mute_zc);
            5:  return int'(in_level);
            6:  return int'(volume);
            7:  return int'(loud_en);
            8:  return int'(loud_level);
            9:  return int'(treble);
            10: return int'(bass);
            11: return int'(att_rl);
            12: return int'(att_fl);
            13: return int'(att_rr);
            default: return int'(att_fr);
        endcase
    endfunction

    function automatic string tag_of(input int sel);
        if (sel <= 4) return "R5";
        if (sel == 5) return "R6";
        if (sel <= 8) return "R7";
        return "R8";
    endfunction

    // driver side: queue expected field values, then hand over to the monitor
    task automatic flush(input string ctx);
        for (int s = 0; s < 15; s++) begin
            item_t it;
            it.sel = s;
            it.exp = exp_of(s);
            it.req = {ctx, " ", tag_of(s)};
            sbq.push_back(it);
        end
        -> sb_evt;
        repeat (4) @(negedge clk);
    endtask

    // monitor side
    initial begin
        forever begin
            @(sb_evt);
            @(negedge clk);
            while (sbq.size() > 0) begin
                item_t it;
                it = sbq.pop_front();
                chk(it.req, obs_of(it.sel), it.exp);
            end
        end
    end

    task automatic wait_q;
        repeat (Q) @(negedge clk);
    endtask

    task automatic i2c_start;
        sda_m = 1'b1; wait_q;
        scl_m = 1'b1; wait_q;
        sda_m = 1'b0; wait_q;
        scl_m = 1'b0; wait_q;
    endtask

    task automatic i2c_stop;
        sda_m = 1'b0; wait_q;
        scl_m = 1'b1; wait_q;
        sda_m = 1'b1; wait_q;
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; wait_q;
            scl_m = 1'b1; wait_q; wait_q;
            scl_m = 1'b0; wait_q;
        end
        sda_m = 1'b1; wait_q;
        scl_m = 1'b1; wait_q;
        ack = ~sda_line; wait_q;
        scl_m = 1'b0; wait_q;
    endtask

    task automatic recv_byte(input logic give_ack, output logic [7:0] b);
        for (int i = 7; i >= 0; i--) begin
            sda_m = 1'b1; wait_q;
            scl_m = 1'b1; wait_q;
            b[i] = sda_line; wait_q;
            scl_m = 1'b0; wait_q;
        end
        sda_m = ~give_ack; wait_q;
        scl_m = 1'b1; wait_q; wait_q;
        scl_m = 1'b0; wait_q;
        sda_m = 1'b1;
    endtask

    task automatic wr_frame(input logic [7:0] abyte, input logic [7:0] sub,
                            input logic [7:0] d[$], input string ctx);
        logic a;
        int   good;
        good = (abyte == 8'h87) ? 1 : 0;
        i2c_start;
        send_byte(abyte, a);
        chk({ctx, " R2 address ack"}, int'(a), good);
        send_byte(sub, a);
        chk({ctx, " R3 index ack"}, int'(a), good);
        foreach (d[i]) begin
            send_byte(d[i], a);
            chk({ctx, " R4 data ack"}, int'(a), good);
            if ((good == 1) && ((int'(sub) + i) <= 8)) mdl[int'(sub) + i] = d[i];
        end
        i2c_stop;
        flush(ctx);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] dq[$];
        logic [7:0] b1, b2;
        logic a;
        for (int i = 0; i < 9; i++) mdl[i] = (i == 4) ? 8'h01 : 8'h00;
        repeat (6) @(negedge clk);
        rst_n = 1'b1;
        repeat (6) @(negedge clk);

        // R1 reset state
        flush("R1 reset");
        chk("R1 sda released", int'(sda_oe), 0);

        // R3 R7 single write, bit 7 ignored
        dq = {8'hBF};
        wr_frame(8'h87, 8'h02, dq, "R3 single");

        // R3 auto-increment across the whole map
        dq = {8'hA6, 8'h0C, 8'h95, 8'h6A, 8'h3C, 8'hF7, 8'h2B, 8'h1D, 8'h0E};
        wr_frame(8'h87, 8'h00, dq, "R3 burst");

        // R6 level saturation and pass-through
        dq = {8'hFF};
        wr_frame(8'h87, 8'h01, dq, "R6 level 15");
        dq = {8'h0A};
        wr_frame(8'h87, 8'h01, dq, "R6 level 10");
        dq = {8'h09};
        wr_frame(8'h87, 8'h01, dq, "R6 level 9");

        // R4 write past the end of the map
        dq = {8'h12, 8'h34, 8'h56, 8'h78};
        wr_frame(8'h87, 8'h07, dq, "R4 overrun");

        // R2 foreign address ignored
        dq = {8'h05, 8'h00};
        wr_frame(8'h85, 8'h02, dq, "R2 foreign");

        // R9 read with flags changing during the first byte
        clip_in_flag = 1'b1; clip_tone_flag = 1'b0; zc_mute_flag = 1'b1;
        i2c_start;
        send_byte(8'h86, a);
        chk("R9 read address ack", int'(a), 1);
        fork
            recv_byte(1'b1, b1);
            begin
                repeat (12 * Q) @(negedge clk);
                {clip_in_flag, clip_tone_flag, zc_mute_flag} = 3'b010;
            end
        join
        recv_byte(1'b0, b2);
        chk("R9 first byte flags", int'(b1[7:5]), 5);
        chk("R9 first byte low bits", int'(b1[4:0]), 0);
        chk("R9 second byte flags", int'(b2[7:5]), 2);
        repeat (Q) @(negedge clk);
        chk("R9 released after nack", int'(sda_oe), 0);
        i2c_stop;
        flush("R11 after read");

        // R10 stop before any data byte
        i2c_start;
        send_byte(8'h87, a);
        chk("R10 address ack", int'(a), 1);
        send_byte(8'h02, a);
        i2c_stop;
        chk("R10 sda released after stop", int'(sda_oe), 0);
        flush("R10 stop early");

        // R5 second switch pattern
        dq = {8'h59};
        wr_frame(8'h87, 8'h00, dq, "R5 switch");

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule